// File: doc/BRIEF.md
# Two-Bank I2C Serial EEPROM Slave

This block is a synthesizable model of a serial EEPROM that answers on an I2C bus as a slave. Its storage is split into two equal banks. Each bank keeps its own address counter, and a bit in the control byte chooses which bank and which counter a transfer uses. The block oversamples SCL and SDA with the system clock. It pulls SDA low through a single output-enable and never drives the line high.

A master first writes a control byte. It then sends a two-byte address to place the chosen counter, followed by up to a page of data. Incoming data goes into a page buffer. The array is updated only when a stop condition ends the write, and a fixed internal write cycle follows. During that cycle the device refuses its control byte, so the master polls until it is acknowledged again. A read starts at the current counter of the selected bank and continues for as long as the master acknowledges. The usual random read is an address write that is cut short by a repeated start, followed by a read.

Top module: `i2cee_slave`

## Requirements
- R1: The device acknowledges a control byte only when bits 7:4 are 1010 and bits 2:1 equal `strap_i`. Any other control byte gets no acknowledge, and the bus is ignored until the next start.
- R2: Bit 3 of the control byte selects the bank (0 low, 1 high). Bit 0 selects a read (1) or a write (0). Each bank has its own counter, and a transfer on one bank leaves the other bank's counter unchanged.
- R3: A write sends the address high byte and then the low byte, and both are acknowledged. The selected counter loads the low BANK_AW bits of the 15-bit value {high[6:0], low}. Bit 7 of the high byte has no effect.
- R4: Each data byte of a write is acknowledged and lands at the current counter. The counter then advances in its low 6 bits only, so a page of 64 bytes wraps from offset 63 back to offset 0. When a page offset is written more than once, the last byte written to it is kept.
- R5: A stop that ends a write carrying at least one data byte commits the page and starts a busy period of max(WRITE_CYCLES, 64) clocks. During the busy period a matching control byte is not acknowledged. After it ends, the control byte is acknowledged again.
- R6: A read sends the byte at the selected counter MSB first and then increments that counter. A master acknowledge (0) gets the next byte. A master not-acknowledge (1) makes the slave release SDA and stay off the bus until the next start.
- R7: During a read the counter wraps from the last address of the bank to address 0 of the same bank.
- R8: A repeated start that cuts off a write commits nothing and starts no busy period. The counter keeps the loaded address, advanced once for each data byte received.
- R9: After reset SDA is released, both counters are 0, every location reads 0x00 and the device is not busy.
- R10: The slave changes its SDA drive only while SCL is low, and it releases SDA on every start and stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock level |
| sda_i | input | 1 | Bus data level (wired-AND of all drivers) |
| strap_i | input | 2 | Device address straps compared with control bits 2:1 |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
The bench goes after page wrap with a 66-byte write. A design that advanced the full counter would spill into the next page instead of overwriting offsets 0 and 1. It also checks the read wrap at the end of a bank, which a wrong design would carry into the other bank's addresses. A write cut off by a repeated start must leave memory untouched and must not cause a busy NAK; committing on any condition rather than only on stop would fail both checks. It checks that a bank change preserves the other bank's counter, and that SDA stays released after a master NAK. Random page writes with random read-back are compared with a model in the bench.

// File: rtl/i2cee_pkg.sv
`timescale 1ns/1ps
package i2cee_pkg;

    localparam logic [3:0] DEV_CODE = 4'b1010;
    localparam int         PAGE_AW  = 6;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CTRL,
        ST_AHI,
        ST_ALO,
        ST_WDAT,
        ST_RDAT
    } ee_state_e;

    typedef struct packed {
        logic scl;
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_ev_t;

    function automatic logic ctrl_hit(input logic [7:0] b, input logic [1:0] strap);
        return (b[7:4] == DEV_CODE) && (b[2:1] == strap);
    endfunction

endpackage

// File: rtl/i2cee_bus_sense.sv
`timescale 1ns/1ps
module i2cee_bus_sense
    import i2cee_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev
);

    localparam int LINES = 2;

    logic [LINES-1:0] raw;
    logic [LINES-1:0] lvl;
    logic [LINES-1:0] dly;

    assign raw = {scl_i, sda_i};

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [SYNC_STAGES-1:0] sy_q;
        logic                   d_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                sy_q <= '1;
                d_q  <= 1'b1;
            end else begin
                sy_q <= {sy_q[SYNC_STAGES-2:0], raw[g]};
                d_q  <= sy_q[SYNC_STAGES-1];
            end
        end
        assign lvl[g] = sy_q[SYNC_STAGES-1];
        assign dly[g] = d_q;
    end

    always_comb begin
        ev.scl      = lvl[1];
        ev.sda      = lvl[0];
        ev.scl_rise = lvl[1] & ~dly[1];
        ev.scl_fall = ~lvl[1] & dly[1];
        ev.start    = lvl[1] & dly[1] & dly[0] & ~lvl[0];
        ev.stop     = lvl[1] & dly[1] & ~dly[0] & lvl[0];
    end

endmodule

// File: rtl/i2cee_store.sv
`timescale 1ns/1ps
module i2cee_store
    import i2cee_pkg::*;
#(
    parameter int BANK_AW      = 7,
    parameter int WRITE_CYCLES = 300
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        buf_clr,
    input  logic                        buf_we,
    input  logic [PAGE_AW-1:0]          buf_off,
    input  logic [7:0]                  buf_din,
    input  logic                        commit,
    input  logic [BANK_AW-PAGE_AW:0]    commit_page,
    input  logic [BANK_AW:0]            rd_addr,
    output logic [7:0]                  rd_data,
    output logic                        busy
);

    localparam int MEM_AW   = BANK_AW + 1;
    localparam int DEPTH    = 1 << MEM_AW;
    localparam int PAGE_N   = 1 << PAGE_AW;
    localparam int BUSY_LEN = (WRITE_CYCLES > PAGE_N) ? WRITE_CYCLES : PAGE_N;
    localparam int TW       = $clog2(BUSY_LEN + 1);

    logic [7:0]              mem_q  [DEPTH];
    logic [7:0]              pbuf_q [PAGE_N];
    logic [PAGE_N-1:0]       pmask_q;
    logic                    busy_q;
    logic [TW-1:0]           timer_q;
    logic [PAGE_AW:0]        idx_q;
    logic [BANK_AW-PAGE_AW:0] page_q;
    logic                    idx_live;

    assign idx_live = ~idx_q[PAGE_AW];
    assign rd_data  = mem_q[rd_addr];
    assign busy     = busy_q;

    always_ff @(posedge clk) begin
        if (buf_we) pbuf_q[buf_off] <= buf_din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pmask_q <= '0;
        end else if (buf_clr) begin
            pmask_q <= '0;
        end else if (buf_we) begin
            pmask_q[buf_off] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
            busy_q  <= 1'b0;
            timer_q <= '0;
            idx_q   <= '0;
            page_q  <= '0;
        end else if (commit && !busy_q) begin
            busy_q  <= 1'b1;
            timer_q <= '0;
            idx_q   <= '0;
            page_q  <= commit_page;
        end else if (busy_q) begin
            timer_q <= timer_q + 1'b1;
            if (timer_q == TW'(BUSY_LEN - 1)) busy_q <= 1'b0;
            if (idx_live) begin
                if (pmask_q[idx_q[PAGE_AW-1:0]])
                    mem_q[{page_q, idx_q[PAGE_AW-1:0]}] <= pbuf_q[idx_q[PAGE_AW-1:0]];
                idx_q <= idx_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/i2cee_ctrl.sv
`timescale 1ns/1ps
module i2cee_ctrl
    import i2cee_pkg::*;
#(
    parameter int BANK_AW = 7
) (
    input  logic                      clk,
    input  logic                      rst,
    input  bus_ev_t                   ev,
    input  logic [1:0]                strap,
    input  logic                      busy,
    input  logic [7:0]                rd_data,
    output logic                      sda_oe,
    output logic                      buf_clr,
    output logic                      buf_we,
    output logic [PAGE_AW-1:0]        buf_off,
    output logic [7:0]                buf_din,
    output logic                      commit,
    output logic [BANK_AW-PAGE_AW:0]  commit_page,
    output logic [BANK_AW:0]          rd_addr
);

    ee_state_e          state_q;
    logic [3:0]         bit_q;
    logic               in_ack_q;
    logic [7:0]         sh_q;
    logic               oe_q;
    logic               ackgo_q;
    logic               bank_q;
    logic               rnw_q;
    logic [7:0]         hi_q;
    logic               pend_q;
    logic               mnak_q;
    logic [BANK_AW-1:0] cnt_q [2];
    logic               clr_q, we_q, commit_q;
    logic [PAGE_AW-1:0] off_q;
    logic [7:0]         din_q;

    logic [BANK_AW-1:0] cur;
    logic [14:0]        load_addr;

    assign cur       = cnt_q[bank_q];
    assign load_addr = {hi_q[6:0], sh_q};

    assign sda_oe      = oe_q;
    assign buf_clr     = clr_q;
    assign buf_we      = we_q;
    assign buf_off     = off_q;
    assign buf_din     = din_q;
    assign commit      = commit_q;
    assign commit_page = {bank_q, cur[BANK_AW-1:PAGE_AW]};
    assign rd_addr     = {bank_q, cur};

    function automatic logic [BANK_AW-1:0] page_step(input logic [BANK_AW-1:0] c);
        return {c[BANK_AW-1:PAGE_AW], c[PAGE_AW-1:0] + 1'b1};
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            bit_q    <= '0;
            in_ack_q <= 1'b0;
            sh_q     <= '0;
            oe_q     <= 1'b0;
            ackgo_q  <= 1'b0;
            bank_q   <= 1'b0;
            rnw_q    <= 1'b0;
            hi_q     <= '0;
            pend_q   <= 1'b0;
            mnak_q   <= 1'b0;
            cnt_q    <= '{default: '0};
            clr_q    <= 1'b0;
            we_q     <= 1'b0;
            commit_q <= 1'b0;
            off_q    <= '0;
            din_q    <= '0;
        end else begin
            clr_q    <= 1'b0;
            we_q     <= 1'b0;
            commit_q <= 1'b0;
            if (ev.start) begin
                state_q  <= ST_CTRL;
                bit_q    <= '0;
                in_ack_q <= 1'b0;
                oe_q     <= 1'b0;
                pend_q   <= 1'b0;
            end else if (ev.stop) begin
                state_q  <= ST_IDLE;
                bit_q    <= '0;
                in_ack_q <= 1'b0;
                oe_q     <= 1'b0;
                commit_q <= pend_q && (state_q == ST_WDAT);
                pend_q   <= 1'b0;
            end else if (state_q != ST_IDLE) begin
                if (ev.scl_rise) begin
                    if (in_ack_q) begin
                        if (state_q == ST_RDAT) mnak_q <= ev.sda;
                    end else begin
                        bit_q <= bit_q + 1'b1;
                        if (state_q != ST_RDAT) sh_q <= {sh_q[6:0], ev.sda};
                    end
                end else if (ev.scl_fall) begin
                    if (!in_ack_q && bit_q == 4'd8) begin
                        in_ack_q <= 1'b1;
                        case (state_q)
                            ST_CTRL: begin
                                ackgo_q <= ctrl_hit(sh_q, strap) && !busy;
                                oe_q    <= ctrl_hit(sh_q, strap) && !busy;
                                if (ctrl_hit(sh_q, strap) && !busy) begin
                                    bank_q <= sh_q[3];
                                    rnw_q  <= sh_q[0];
                                end
                            end
                            ST_AHI: begin
                                hi_q <= sh_q;
                                oe_q <= 1'b1;
                            end
                            ST_ALO: begin
                                cnt_q[bank_q] <= load_addr[BANK_AW-1:0];
                                clr_q         <= 1'b1;
                                oe_q          <= 1'b1;
                            end
                            ST_WDAT: begin
                                we_q          <= 1'b1;
                                off_q         <= cur[PAGE_AW-1:0];
                                din_q         <= sh_q;
                                cnt_q[bank_q] <= page_step(cur);
                                pend_q        <= 1'b1;
                                oe_q          <= 1'b1;
                            end
                            default: oe_q <= 1'b0;
                        endcase
                    end else if (in_ack_q) begin
                        in_ack_q <= 1'b0;
                        bit_q    <= '0;
                        oe_q     <= 1'b0;
                        case (state_q)
                            ST_CTRL: begin
                                if (!ackgo_q) begin
                                    state_q <= ST_IDLE;
                                end else if (rnw_q) begin
                                    state_q       <= ST_RDAT;
                                    sh_q          <= rd_data;
                                    oe_q          <= ~rd_data[7];
                                    cnt_q[bank_q] <= cur + 1'b1;
                                end else begin
                                    state_q <= ST_AHI;
                                end
                            end
                            ST_AHI:  state_q <= ST_ALO;
                            ST_ALO:  state_q <= ST_WDAT;
                            ST_WDAT: state_q <= ST_WDAT;
                            ST_RDAT: begin
                                if (mnak_q) begin
                                    state_q <= ST_IDLE;
                                end else begin
                                    sh_q          <= rd_data;
                                    oe_q          <= ~rd_data[7];
                                    cnt_q[bank_q] <= cur + 1'b1;
                                end
                            end
                            default: state_q <= ST_IDLE;
                        endcase
                    end else if (state_q == ST_RDAT && bit_q != 4'd0) begin
                        sh_q <= {sh_q[6:0], 1'b0};
                        oe_q <= ~sh_q[6];
                    end
                end
            end
        end
    end

endmodule

// File: rtl/i2cee_slave.sv
`timescale 1ns/1ps
module i2cee_slave
    import i2cee_pkg::*;
#(
    parameter int BANK_AW      = 7,
    parameter int WRITE_CYCLES = 300
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [1:0] strap_i,
    output logic       sda_oe_o
);

    bus_ev_t                   bus_ev;
    logic                      buf_clr, buf_we, commit, mem_busy;
    logic [PAGE_AW-1:0]        buf_off;
    logic [7:0]                buf_din, rd_data;
    logic [BANK_AW-PAGE_AW:0]  commit_page;
    logic [BANK_AW:0]          rd_addr;
    logic                      scl_lvl, start_det, stop_det;

    assign scl_lvl   = bus_ev.scl;
    assign start_det = bus_ev.start;
    assign stop_det  = bus_ev.stop;

    i2cee_bus_sense #(.SYNC_STAGES(2)) sense_i (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (bus_ev)
    );

    i2cee_ctrl #(.BANK_AW(BANK_AW)) ctrl_i (
        .clk         (clk),
        .rst         (rst),
        .ev          (bus_ev),
        .strap       (strap_i),
        .busy        (mem_busy),
        .rd_data     (rd_data),
        .sda_oe      (sda_oe_o),
        .buf_clr     (buf_clr),
        .buf_we      (buf_we),
        .buf_off     (buf_off),
        .buf_din     (buf_din),
        .commit      (commit),
        .commit_page (commit_page),
        .rd_addr     (rd_addr)
    );

    i2cee_store #(.BANK_AW(BANK_AW), .WRITE_CYCLES(WRITE_CYCLES)) store_i (
        .clk         (clk),
        .rst         (rst),
        .buf_clr     (buf_clr),
        .buf_we      (buf_we),
        .buf_off     (buf_off),
        .buf_din     (buf_din),
        .commit      (commit),
        .commit_page (commit_page),
        .rd_addr     (rd_addr),
        .rd_data     (rd_data),
        .busy        (mem_busy)
    );

endmodule

// File: rtl/i2cee_chk.sv
`timescale 1ns/1ps
module i2cee_chk (
    input logic clk,
    input logic rst,
    input logic scl_lvl,
    input logic start_det,
    input logic stop_det,
    input logic sda_oe,
    input logic busy,
    input logic buf_we
);

    // R10
    oe_moves_scl_low_chk: assert property (@(posedge clk) disable iff (rst)
        (sda_oe != $past(sda_oe)) |-> (!scl_lvl || $past(start_det) || $past(stop_det)));

    // R10
    start_release_chk: assert property (@(posedge clk) disable iff (rst)
        start_det |=> !sda_oe);

    // R10
    stop_release_chk: assert property (@(posedge clk) disable iff (rst)
        stop_det |=> !sda_oe);

    // R5
    busy_from_stop_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(stop_det, 2));

    // R5
    no_fill_while_busy_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> !buf_we);

    // R9
    reset_quiet_chk: assert property (@(posedge clk)
        $fell(rst) |-> (!busy && !sda_oe));

endmodule

bind i2cee_slave i2cee_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .scl_lvl   (scl_lvl),
    .start_det (start_det),
    .stop_det  (stop_det),
    .sda_oe    (sda_oe_o),
    .busy      (mem_busy),
    .buf_we    (buf_we)
);

// File: tb/i2cee_slave_tb_top.sv
`timescale 1ns/1ps
module i2cee_slave_tb_top;

    localparam int BANK_AW = 7;
    localparam int BANK    = 1 << BANK_AW;
    localparam int Q       = 5;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl = 1'b1;
    logic       sda_m = 1'b1;
    logic [1:0] strap = 2'b10;
    logic       sda_oe;
    logic       sda_line;

    assign sda_line = sda_m & ~sda_oe;

    always #2.5 clk = ~clk;

    i2cee_slave #(.BANK_AW(BANK_AW), .WRITE_CYCLES(300)) dut_i (
        .clk      (clk),
        .rst      (rst),
        .scl_i    (scl),
        .sda_i    (sda_line),
        .strap_i  (strap),
        .sda_oe_o (sda_oe)
    );

    int         n_chk = 0;
    int         n_fail = 0;
    logic [7:0] ref_mem [2*BANK];
    int         ref_cnt [2];
    logic [7:0] wbuf [80];

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic qw();
        repeat (Q) @(negedge clk);
    endtask

    task automatic i2c_start();
        sda_m = 1'b1; qw(); scl = 1'b1; qw(); sda_m = 1'b0; qw(); scl = 1'b0; qw();
    endtask

    task automatic i2c_stop();
        sda_m = 1'b0; qw(); scl = 1'b1; qw(); sda_m = 1'b1; qw(); qw();
    endtask

    task automatic put_bit(input logic b);
        sda_m = b; qw(); scl = 1'b1; qw(); qw(); scl = 1'b0; qw();
    endtask

    task automatic get_bit(output logic b);
        sda_m = 1'b1; qw(); scl = 1'b1; qw(); b = sda_line; qw(); scl = 1'b0; qw();
    endtask

    task automatic send_byte(input logic [7:0] d, output logic nak);
        for (int i = 7; i >= 0; i--) put_bit(d[i]);
        get_bit(nak);
    endtask

    task automatic recv_byte(input logic ackbit, output logic [7:0] d);
        logic b;
        for (int i = 0; i < 8; i++) begin
            get_bit(b);
            d = {d[6:0], b};
        end
        put_bit(ackbit);
    endtask

    function automatic logic [7:0] ctl(input logic bank, input logic rnw);
        return {4'b1010, bank, strap, rnw};
    endfunction

    // address-phase of a write; leaves the bus held after the low byte
    task automatic set_addr(input logic bank, input logic [7:0] hi, input logic [7:0] lo);
        logic nak;
        i2c_start();
        send_byte(ctl(bank, 1'b0), nak); check("R1 ctrl ack", nak, 0);
        send_byte(hi, nak);              check("R3 hi ack", nak, 0);
        send_byte(lo, nak);              check("R3 lo ack", nak, 0);
        ref_cnt[bank] = int'({hi[6:0], lo}) % BANK;
    endtask

    task automatic do_write(input logic bank, input logic [7:0] hi, input logic [7:0] lo,
                            input int n, input bit abort);
        logic nak;
        int   c;
        set_addr(bank, hi, lo);
        c = ref_cnt[bank];
        for (int k = 0; k < n; k++) begin
            send_byte(wbuf[k], nak); check("R4 data ack", nak, 0);
            if (!abort) ref_mem[int'(bank) * BANK + c] = wbuf[k];
            c = (c / 64) * 64 + ((c + 1) % 64);
        end
        ref_cnt[bank] = c;
        if (!abort) i2c_stop();
    endtask

    task automatic do_read(input logic bank, input int n, input string req, input bit idle_chk);
        logic       nak;
        logic [7:0] d;
        logic       b;
        i2c_start();
        send_byte(ctl(bank, 1'b1), nak); check({req, " read ctrl ack"}, nak, 0);
        for (int k = 0; k < n; k++) begin
            recv_byte(k == n - 1, d);
            check({req, " read data"}, d, ref_mem[int'(bank) * BANK + ref_cnt[bank]]);
            ref_cnt[bank] = (ref_cnt[bank] + 1) % BANK;
        end
        if (idle_chk) begin
            for (int k = 0; k < 9; k++) begin
                get_bit(b);
                check("R6 released after NAK", b, 1);
            end
        end
        i2c_stop();
        check("R10 released after stop", sda_oe, 0);
    endtask

    task automatic wait_ready(input logic bank, output int polls);
        logic nak;
        polls = 0;
        do begin
            i2c_start();
            send_byte(ctl(bank, 1'b0), nak);
            i2c_stop();
            polls++;
        end while (nak && polls < 60);
        check("R5 ready after busy", nak, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog R5 actual=timeout expected=finished");
        summary();
        $finish;
    end

    initial begin
        logic nak;
        int   polls;
        void'($urandom(32'd4242));
        for (int i = 0; i < 2 * BANK; i++) ref_mem[i] = 8'h00;
        ref_cnt[0] = 0;
        ref_cnt[1] = 0;
        repeat (6) @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);

        // R9 reset state
        check("R9 sda released", sda_oe, 0);
        do_read(1'b0, 2, "R9", 1'b0);

        // R1 wrong strap and wrong device code
        i2c_start();
        send_byte({4'b1010, 1'b0, ~strap, 1'b0}, nak); check("R1 strap mismatch nak", nak, 1);
        send_byte(8'h00, nak);                          check("R1 ignored after mismatch", nak, 1);
        i2c_stop();
        i2c_start();
        send_byte({4'b1011, 1'b0, strap, 1'b0}, nak);   check("R1 code mismatch nak", nak, 1);
        i2c_stop();

        // R5 busy NAK then ACK; R3/R6 read back
        for (int k = 0; k < 4; k++) wbuf[k] = 8'hC0 + 8'(k);
        do_write(1'b0, 8'h00, 8'h10, 4, 1'b0);
        wait_ready(1'b0, polls);
        check("R5 first poll NAKed", int'(polls > 1), 1);
        set_addr(1'b0, 8'h00, 8'h10);
        do_read(1'b0, 4, "R6", 1'b0);

        // R4 wrap inside page, bank 1
        for (int k = 0; k < 4; k++) wbuf[k] = 8'h50 + 8'(k);
        do_write(1'b1, 8'h00, 8'h3E, 4, 1'b0);
        wait_ready(1'b1, polls);
        set_addr(1'b1, 8'h00, 8'h3E);
        do_read(1'b1, 4, "R4", 1'b0);
        set_addr(1'b1, 8'h00, 8'h00);
        do_read(1'b1, 2, "R4", 1'b0);

        // R4 66-byte page write overwrites offsets 0 and 1
        for (int k = 0; k < 66; k++) wbuf[k] = 8'($urandom);
        do_write(1'b0, 8'h00, 8'h40, 66, 1'b0);
        wait_ready(1'b0, polls);
        set_addr(1'b0, 8'h00, 8'h40);
        do_read(1'b0, 64, "R4", 1'b0);

        // R3 high-byte MSB and bits above the bank have no effect
        wbuf[0] = 8'h3C;
        do_write(1'b0, 8'h80, 8'h20, 1, 1'b0);
        wait_ready(1'b0, polls);
        set_addr(1'b0, 8'h00, 8'h20);
        do_read(1'b0, 1, "R3", 1'b0);
        wbuf[0] = 8'hA7;
        do_write(1'b0, 8'h7F, 8'h30, 1, 1'b0);
        wait_ready(1'b0, polls);
        set_addr(1'b0, 8'h00, 8'h30);
        do_read(1'b0, 1, "R3", 1'b0);

        // R2 bank 1 random read leaves bank 0 counter in place
        set_addr(1'b1, 8'h00, 8'h05);
        do_read(1'b1, 1, "R2", 1'b0);
        do_read(1'b0, 2, "R2", 1'b0);

        // R7 wrap at end of bank
        set_addr(1'b1, 8'h00, 8'h7E);
        do_read(1'b1, 4, "R7", 1'b0);

        // R8 aborted write: no commit, no busy, counter advanced
        wbuf[0] = 8'h99;
        do_write(1'b0, 8'h00, 8'h50, 1, 1'b1);
        do_read(1'b0, 1, "R8", 1'b0);
        set_addr(1'b0, 8'h00, 8'h50);
        do_read(1'b0, 1, "R8", 1'b0);

        // R6 slave stays off the bus after master NAK
        set_addr(1'b0, 8'h00, 8'h10);
        do_read(1'b0, 2, "R6", 1'b1);

        // random page writes and read-back
        for (int it = 0; it < 8; it++) begin
            logic       bk;
            logic [7:0] lo;
            int         n;
            bk = 1'($urandom);
            lo = 8'($urandom) & 8'h7F;
            n  = 1 + int'($urandom % 6);
            for (int k = 0; k < n; k++) wbuf[k] = 8'($urandom);
            do_write(bk, 8'($urandom), lo, n, 1'b0);
            wait_ready(bk, polls);
            set_addr(bk, 8'h00, lo);
            do_read(bk, n + 2, "R4 random", 1'b0);
        end

        summary();
        $finish;
    end

endmodule